// File: doc/BRIEF.md
# Self-Checking (15,7) Systematic Encoder

This block turns a 7-bit information word into a 15-bit systematic codeword for storage in a protected memory. The low seven bits of the codeword copy the data and the upper eight are parity bits. Each parity bit is the XOR of a fixed subset of the data bits. The code has minimum distance 5.

A second, independent set of XOR trees computes the 8-bit syndrome of the word the encoder actually produced. The syndrome is the parity-check matrix (transposed parity part beside an 8x8 identity) applied to that word. A nonzero syndrome withholds the output strobe and runs the encoding again in the next cycle. A word that passed only after one or more re-encodes carries a retry flag. If the syndrome is still nonzero after the third re-encode, the block raises a sticky fatal flag and stops accepting data until reset.

A test input XORs an error mask onto the encoder output while a word is being checked. This lets the retry path be exercised from outside the block. Reset is asynchronous active-low, and its release is synchronised inside the block.

Top module: `fse_encoder`

## Requirements
- R1: On a released word, `out_code[6:0]` equals the accepted data `d`. The parity bits are `out_code[7]=d0^d4^d6`, `[8]=d0^d1^d4^d5^d6`, `[9]=d0^d1^d2^d4^d5`, `[10]=d1^d2^d3^d5^d6`, `[11]=d0^d2^d3`, `[12]=d1^d3^d4`, `[13]=d2^d4^d5` and `[14]=d3^d5^d6`.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. When no error is seen, `out_valid` is high for exactly the one cycle that follows the acceptance. `in_ready` is high only while the block is idle.
- R3: A nonzero `inj_mask` of weight one or two, applied during a check cycle, holds `out_valid` low in that cycle. `out_valid` is never high with a codeword whose syndrome is nonzero.
- R4: After j failed checks (1 ≤ j ≤ 3), a clean check releases the word in cycle j+1 after acceptance. The released word is the correct codeword and `out_retry` is high with it.
- R5: A word that passes its first check is released with `out_retry` low.
- R6: If the check fails four times in a row (the first try plus three re-encodes), `fatal` rises after the fourth failing check. `fatal` then stays high, with `in_ready` and `out_valid` low, until reset.
- R7: While reset is asserted and once it is released, `out_valid`, `out_retry` and `fatal` are low. `in_ready` is high again within three cycles of the release.
- R8: `inj_mask` is ignored while the block is idle. It neither delays nor counts toward the retry limit of the next word.
- R9: Changes on `in_data` and `in_valid` while the block is busy have no effect. The released word belongs to the accepted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| in_data | input | 7 | Information word |
| inj_mask | input | 15 | Test error mask XORed onto the encoder output during checks |
| out_valid | output | 1 | One-cycle strobe: `out_code` is a checked codeword |
| out_code | output | 15 | Codeword, valid while `out_valid` is high |
| out_retry | output | 1 | Released word needed at least one re-encode |
| fatal | output | 1 | Sticky: retry limit exhausted |

## Verification
A clean word's strobe and codeword are due one cycle after the accepting edge. With j failed checks they are due j+1 cycles after it. `fatal` is due right after the edge that closes the fourth failing check. The bench drives inputs and the mask at the falling edge. It samples the outputs one time unit later, inside the same cycle, because the strobe and codeword follow the registered state through logic only. It also confirms that `out_valid` is low in every check cycle before the due one and in the cycle after it.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam int K = 7;
  localparam int Q = 8;
  localparam int N = K + Q;
  localparam int RETRY_MAX = 3;

  // Row j: data bits that feed parity bit K+j
  localparam logic [K-1:0] PAR_SEL [Q] = '{
    7'b1010001,
    7'b1110011,
    7'b0110111,
    7'b1101110,
    7'b0001101,
    7'b0011010,
    7'b0110100,
    7'b1101000
  };

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_DEAD  = 2'd2
  } fse_state_e;
endpackage

// File: rtl/fse_rst_sync.sv
module fse_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fse_parity_gen.sv
module fse_parity_gen
  import fse_pkg::*;
(
  input  logic [K-1:0] data,
  output logic [N-1:0] code
);
  logic [Q-1:0] par;

  for (genvar j = 0; j < Q; j++) begin : g_par
    assign par[j] = ^(data & PAR_SEL[j]);
  end

  assign code = {par, data};
endmodule

// File: rtl/fse_syndrome_chk.sv
module fse_syndrome_chk
  import fse_pkg::*;
(
  input  logic [N-1:0] code,
  output logic [Q-1:0] syndrome,
  output logic         clean
);
  // Own XOR trees over the observed word, no reuse of encoder nets
  for (genvar j = 0; j < Q; j++) begin : g_syn
    logic [K:0] row_bits;
    assign row_bits    = {code[K+j], code[K-1:0] & PAR_SEL[j]};
    assign syndrome[j] = ^row_bits;
  end

  assign clean = (syndrome == '0);
endmodule

// File: rtl/fse_ctrl.sv
module fse_ctrl
  import fse_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [K-1:0] in_data,
  input  logic         clean,
  output logic         idle,
  output logic         checking,
  output logic [K-1:0] data_q,
  output logic         out_valid,
  output logic         out_retry,
  output logic         fatal
);
  localparam int CW = $clog2(RETRY_MAX + 1);

  fse_state_e      state_q, state_d;
  logic [CW-1:0]   tries_q, tries_d;
  logic            retried_q, retried_d;
  logic            data_en;

  always_comb begin
    state_d   = state_q;
    tries_d   = tries_q;
    retried_d = retried_q;
    data_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          data_en   = 1'b1;
          state_d   = ST_CHECK;
          tries_d   = '0;
          retried_d = 1'b0;
        end
      end
      ST_CHECK: begin
        if (clean) begin
          state_d = ST_IDLE;
        end else if (tries_q == CW'(RETRY_MAX)) begin
          state_d = ST_DEAD;
        end else begin
          tries_d   = tries_q + 1'b1;
          retried_d = 1'b1;
        end
      end
      ST_DEAD: state_d = ST_DEAD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tries_q   <= '0;
      retried_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      tries_q   <= tries_d;
      retried_q <= retried_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= in_data;
  end

  assign idle      = (state_q == ST_IDLE);
  assign checking  = (state_q == ST_CHECK);
  assign out_valid = checking && clean;
  assign out_retry = out_valid && retried_q;
  assign fatal     = (state_q == ST_DEAD);
endmodule

// File: rtl/fse_encoder.sv
module fse_encoder
  import fse_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [K-1:0] in_data,
  input  logic [N-1:0] inj_mask,
  output logic         out_valid,
  output logic [N-1:0] out_code,
  output logic         out_retry,
  output logic         fatal
);
  logic         srst_n;
  logic         idle;
  logic         checking;
  logic [K-1:0] data_q;
  logic [N-1:0] enc_code;
  logic [N-1:0] obs_code;
  logic [Q-1:0] syndrome;
  logic         clean;
  logic         take;

  fse_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  assign in_ready = idle && srst_n;
  assign take     = in_valid && in_ready;

  fse_parity_gen u_enc (
    .data (data_q),
    .code (enc_code)
  );

  assign obs_code = enc_code ^ (checking ? inj_mask : '0);

  fse_syndrome_chk u_det (
    .code     (obs_code),
    .syndrome (syndrome),
    .clean    (clean)
  );

  fse_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .in_valid  (take),
    .in_data   (in_data),
    .clean     (clean),
    .idle      (idle),
    .checking  (checking),
    .data_q    (data_q),
    .out_valid (out_valid),
    .out_retry (out_retry),
    .fatal     (fatal)
  );

  assign out_code = obs_code;
endmodule

// File: rtl/fse_encoder_chk.sv
module fse_encoder_chk
  import fse_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [K-1:0] in_data,
  input logic         out_valid,
  input logic [N-1:0] out_code,
  input logic         out_retry,
  input logic         fatal
);
  logic [K-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cap_q <= '0;
    else if (in_valid && in_ready) cap_q <= in_data;
  end

  function automatic logic word_ok(input logic [N-1:0] c);
    logic bad;
    bad = 1'b0;
    for (int j = 0; j < Q; j++) begin
      if ((^(c[K-1:0] & PAR_SEL[j])) != c[K+j]) bad = 1'b1;
    end
    return !bad;
  endfunction

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_clean_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> word_ok(out_code));

  p_data_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_code[K-1:0] == cap_q));

  p_retry_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_retry |-> out_valid);

  p_fatal_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);

  p_fatal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> (!out_valid && !in_ready));
endmodule

bind fse_encoder fse_encoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_code  (out_code),
  .out_retry (out_retry),
  .fatal     (fatal)
);

// File: tb/fse_encoder_test.sv
module fse_encoder_test;
  localparam time TCLK = 10ns;
  localparam int  WD_CYCLES = 20000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [6:0]  in_data;
  logic [14:0] inj_mask;
  logic        out_valid;
  logic [14:0] out_code;
  logic        out_retry;
  logic        fatal;

  int checks;
  int errors;

  fse_encoder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .inj_mask  (inj_mask),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_retry (out_retry),
    .fatal     (fatal)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  // {data[24:18], mask[17:3], failed checks[2:0]}
  localparam logic [24:0] VEC [10] = '{
    {7'h00, 15'h0000, 3'd0},
    {7'h7F, 15'h0000, 3'd0},
    {7'h55, 15'h0000, 3'd0},
    {7'h2A, 15'h0000, 3'd0},
    {7'h01, 15'h0001, 3'd1},
    {7'h40, 15'h4000, 3'd2},
    {7'h33, 15'h0180, 3'd3},
    {7'h4C, 15'h0081, 3'd1},
    {7'h12, 15'h0000, 3'd0},
    {7'h6D, 15'h0300, 3'd2}
  };

  function automatic logic [14:0] expect_code(input logic [6:0] d);
    logic [14:0] c;
    c[6:0] = d;
    c[7]   = d[0] ^ d[4] ^ d[6];
    c[8]   = d[0] ^ d[1] ^ d[4] ^ d[5] ^ d[6];
    c[9]   = d[0] ^ d[1] ^ d[2] ^ d[4] ^ d[5];
    c[10]  = d[1] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c[11]  = d[0] ^ d[2] ^ d[3];
    c[12]  = d[1] ^ d[3] ^ d[4];
    c[13]  = d[2] ^ d[4] ^ d[5];
    c[14]  = d[3] ^ d[5] ^ d[6];
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    in_data  = '0;
    inj_mask = '0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 valid in reset", 32'(out_valid), 0);
    check("R7 fatal in reset", 32'(fatal), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R7 ready after reset", 32'(in_ready), 1);
    check("R7 valid after reset", 32'(out_valid), 0);
    check("R7 retry after reset", 32'(out_retry), 0);
  endtask

  // Offer a word at a falling edge, fail `fails` checks with `mask`, then release
  task automatic send(input logic [6:0] d, input logic [14:0] mask, input int fails,
                      input logic busy_noise);
    in_valid = 1'b1;
    in_data  = d;
    #1;
    check("R2 ready when idle", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = busy_noise;
    in_data  = ~d;
    for (int i = 0; i < fails; i++) begin
      inj_mask = mask;
      #1;
      check("R3 held on bad syndrome", 32'(out_valid), 0);
      check("R9 ready low while busy", 32'(in_ready), 0);
      @(negedge clk);
    end
    inj_mask = '0;
    #1;
    check("R2 R4 valid due", 32'(out_valid), 1);
    check("R1 codeword", 32'(out_code), 32'(expect_code(d)));
    if (fails == 0) check("R5 no retry flag", 32'(out_retry), 0);
    else            check("R4 retry flag", 32'(out_retry), 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check("R2 single strobe", 32'(out_valid), 0);
    check("R2 idle again", 32'(in_ready), 1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n  = 1'b1;
    do_reset();

    foreach (VEC[i]) begin
      send(VEC[i][24:18], VEC[i][17:3], int'(VEC[i][2:0]), 1'b0);
    end

    // R9: busy-time input changes
    send(7'h3C, 15'h0002, 1, 1'b1);
    send(7'h5A, 15'h0000, 0, 1'b1);

    // R8: mask while idle, then a word with three failures must still release
    inj_mask = 15'h7FFF;
    repeat (4) begin
      @(negedge clk);
      #1;
      check("R8 idle mask ignored", 32'(out_valid), 0);
    end
    inj_mask = '0;
    send(7'h21, 15'h0400, 3, 1'b0);
    check("R8 no fatal", 32'(fatal), 0);

    // R6: four failing checks
    in_valid = 1'b1;
    in_data  = 7'h0F;
    @(negedge clk);
    in_valid = 1'b0;
    inj_mask = 15'h0010;
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R6 no release", 32'(out_valid), 0);
      check("R6 not yet fatal", 32'(fatal), 0);
      @(negedge clk);
    end
    inj_mask = '0;
    #1;
    check("R6 fatal raised", 32'(fatal), 1);
    check("R6 ready low", 32'(in_ready), 0);
    in_valid = 1'b1;
    in_data  = 7'h11;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1;
      check("R6 fatal sticky", 32'(fatal), 1);
      check("R6 no strobe", 32'(out_valid), 0);
    end
    in_valid = 1'b0;

    do_reset();
    check("R7 fatal cleared", 32'(fatal), 0);
    send(7'h66, 15'h0000, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule